// File: doc/BRIEF.md
# Segment Selector Load and Translate Unit

This block keeps six segment registers: code, data, stack, extra and two spares. Each register has a visible selector part and a hidden part that caches a descriptor. When software loads a selector, the unit reads the 64-bit descriptor from the global or the local descriptor table through a simple request/acknowledge memory read port. It validates the descriptor and writes it into the hidden part of the target register. A rejected load leaves that register exactly as it was.

Translation requests then pick a register, either by default from the kind of access or by an explicit code. The unit applies the offset size, checks the offset against the cached limit and returns a linear address, all from the hidden copy. It never goes back to memory for a translation. A failed load raises a load fault pulse. A translation that breaks a limit, or that uses an unusable segment, raises a translation fault in place of a valid address.

Top module: `segXlateUnit`

## Requirements
- R1: After reset `loadBusy` and `memReq` are 0 and all six segment registers are unusable, so any translation returns `xlFault`=1, `xlValid`=0.
- R2: A selector holds the table index in bits 15:3, the table choice in bit 2 (0 global, 1 local) and the requested privilege in bits 1:0. The descriptor is read as two 32-bit words: first from table base + index*8, then from that address + 4. `memAddr` holds steady while `memReq` waits for `memAck`.
- R3: Descriptor layout. The low word is the 32-bit base. In the high word, bits 19:0 are the limit, 23:20 the type, 24 the system flag, 25 present, 26 granularity, 27 offset size (1 = 32-bit offsets), and 31:28 are reserved. A translation reports the cached type, system flag, offset size and the loaded privilege bits.
- R4: A descriptor with the present bit 0 or any reserved bit set gives a one-cycle `loadFault` and no `loadDone`, and the target register keeps its previous contents.
- R5: A null selector (bits 15:2 all zero) is rejected with `loadFault` when the target is the stack register. Into any other register it completes with `loadDone` and marks the register unusable. Neither case reads memory.
- R6: Register codes are 0 code, 1 data, 2 stack, 3 extra, 4 and 5 spare. A load to code 6 or 7 faults. The access kind selects the register: 0 fetch uses code, 1 stack uses stack, 2 data uses data, 3 uses `xlSeg`. An explicit code of 6 or 7 faults.
- R7: A translation request gives a one-cycle `xlValid` in the next cycle, with `linAddr` = base + effective offset modulo 2^32.
- R8: The effective limit is the limit when granularity is 0, and (limit<<12)|0xFFF when it is 1. An offset equal to the limit is accepted. A larger offset gives `xlFault`, `xlValid`=0 and `linAddr`=0.
- R9: With offset size 0, only the low 16 bits of the offset are used, both for the limit check and for the addition.
- R10: Memory is read only during a load: `memReq` is 0 whenever `loadBusy` is 0.
- R11: A `loadReq` that arrives while a load is in progress is ignored.
- R12: A translation issued in the cycle in which a load commits sees the old contents of the register. The next translation sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadReq | input | 1 | Start a selector load |
| loadSeg | input | 3 | Target register code |
| loadSel | input | 16 | Selector value to load |
| loadBusy | output | 1 | A descriptor fetch is in progress |
| loadDone | output | 1 | One-cycle pulse: load accepted |
| loadFault | output | 1 | One-cycle pulse: load rejected |
| globalBase | input | 32 | Byte address of the global table |
| localBase | input | 32 | Byte address of the local table |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read byte address |
| memAck | input | 1 | Read data valid this cycle |
| memData | input | 32 | Read data word |
| xlReq | input | 1 | Translation request |
| xlKind | input | 2 | Access kind (fetch, stack, data, explicit) |
| xlSeg | input | 3 | Register code for explicit kind |
| xlOffset | input | 32 | Offset within the segment |
| xlValid | output | 1 | Translation succeeded |
| xlFault | output | 1 | Translation failed |
| linAddr | output | 32 | Linear address |
| xlRpl | output | 2 | Privilege bits of the used selector |
| xlType | output | 4 | Cached type field |
| xlSys | output | 1 | Cached system flag |
| xlDb | output | 1 | Cached offset-size flag |

## Verification
A descriptor commit into the data register and a translation through that same register can fall on the same clock edge. The bench lets the memory acknowledge the high word with no wait. In the cycle that carries that acknowledge it raises a data-kind translation. The translation result must carry the old data base while `loadDone` pulses alongside it, and a translation one cycle later must carry the new base.

// File: rtl/segPkg.sv
package segPkg;
  localparam int SEG_W     = 3;
  localparam int SEG_COUNT = 6;
  localparam int SLOTS     = 1 << SEG_W;
  localparam int ADDR_W    = 32;
  localparam int SEL_W     = 16;
  localparam int LIM_W     = 20;
  localparam int PAGE_BITS = 12;

  localparam logic [SEG_W-1:0] SEG_CODE  = 3'd0;
  localparam logic [SEG_W-1:0] SEG_DATA  = 3'd1;
  localparam logic [SEG_W-1:0] SEG_STACK = 3'd2;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_STACK = 2'd1;
  localparam logic [1:0] KIND_DATA  = 2'd2;

  typedef struct packed {
    logic              usable;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [3:0]        segType;
    logic              sysFlag;
    logic              gran;
    logic              db;
    logic [1:0]        rpl;
  } hiddenDesc_t;

  typedef struct packed {
    logic latchReq;
    logic captureLo;
    logic readHi;
    logic commitDesc;
    logic commitNull;
  } ctrlStrobe_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadReq,
  input  logic        reqNull,
  input  logic        reqStack,
  input  logic        reqSegBad,
  input  logic        memAck,
  input  logic        descOk,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        loadBusy,
  output logic        loadDone,
  output logic        loadFault
);
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} ctrlState_t;

  ctrlState_t state, nextState;
  logic doneNext, faultNext;

  always_comb begin
    strobe    = '0;
    nextState = state;
    doneNext  = 1'b0;
    faultNext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (loadReq) begin
          if (reqSegBad) begin
            faultNext = 1'b1;
          end else if (reqNull) begin
            if (reqStack) begin
              faultNext = 1'b1;
            end else begin
              strobe.commitNull = 1'b1;
              doneNext          = 1'b1;
            end
          end else begin
            strobe.latchReq = 1'b1;
            nextState       = ST_LO;
          end
        end
      end
      ST_LO: begin
        if (memAck) begin
          strobe.captureLo = 1'b1;
          nextState        = ST_HI;
        end
      end
      ST_HI: begin
        strobe.readHi = 1'b1;
        if (memAck) begin
          nextState = ST_IDLE;
          if (descOk) begin
            strobe.commitDesc = 1'b1;
            doneNext          = 1'b1;
          end else begin
            faultNext = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign memReq   = (state != ST_IDLE);
  assign loadBusy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      loadDone  <= 1'b0;
      loadFault <= 1'b0;
    end else begin
      state     <= nextState;
      loadDone  <= doneNext;
      loadFault <= faultNext;
    end
  end

  // R4: a load never both succeeds and fails
  p_done_fault_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(loadDone && loadFault));

  // R2: the high word is fetched only after the low word was acknowledged
  p_hi_after_lo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LO && memAck) |=> (state == ST_HI));

  // R11: a request during a fetch does not restart the sequence
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LO && !memAck) |=> (state == ST_LO));
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEL_W-1:0]  loadSel,
  input  logic [SEG_W-1:0]  loadSeg,
  input  logic [ADDR_W-1:0] globalBase,
  input  logic [ADDR_W-1:0] localBase,
  input  logic              memAck,
  input  logic [31:0]       memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              reqNull,
  output logic              reqStack,
  output logic              reqSegBad,
  output logic              descOk,
  input  logic              xlReq,
  input  logic [1:0]        xlKind,
  input  logic [SEG_W-1:0]  xlSeg,
  input  logic [ADDR_W-1:0] xlOffset,
  output logic              xlValid,
  output logic              xlFault,
  output logic [ADDR_W-1:0] linAddr,
  output logic [1:0]        xlRpl,
  output logic [3:0]        xlType,
  output logic              xlSys,
  output logic              xlDb
);
  logic [SEL_W-1:0]  pendSel;
  logic [SEG_W-1:0]  pendSeg;
  logic [31:0]       loWord;
  logic [ADDR_W-1:0] descAddr;
  hiddenDesc_t       newDesc;
  hiddenDesc_t       nullDesc;
  hiddenDesc_t       hid [SLOTS];

  // request classification, straight from the load port
  assign reqNull   = (loadSel[SEL_W-1:2] == '0);
  assign reqStack  = (loadSeg == SEG_STACK);
  assign reqSegBad = (loadSeg >= SEG_W'(SEG_COUNT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSel <= '0;
      pendSeg <= '0;
      loWord  <= '0;
    end else begin
      if (strobe.latchReq) begin
        pendSel <= loadSel;
        pendSeg <= loadSeg;
      end
      if (strobe.captureLo) loWord <= memData;
    end
  end

  // descriptor address generation
  assign descAddr = (pendSel[2] ? localBase : globalBase)
                  + ADDR_W'({pendSel[SEL_W-1:3], 3'b000});
  assign memAddr  = descAddr + (strobe.readHi ? ADDR_W'(4) : ADDR_W'(0));

  // high-word validation and unpacking
  assign descOk = memData[25] && (memData[31:28] == 4'd0);

  always_comb begin
    newDesc         = '0;
    newDesc.usable  = 1'b1;
    newDesc.base    = loWord;
    newDesc.limit   = memData[LIM_W-1:0];
    newDesc.segType = memData[23:20];
    newDesc.sysFlag = memData[24];
    newDesc.gran    = memData[26];
    newDesc.db      = memData[27];
    newDesc.rpl     = pendSel[1:0];
    nullDesc        = '0;
    nullDesc.rpl    = loadSel[1:0];
  end

  // hidden descriptor registers
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < SEG_COUNT) begin : g_real
      always_ff @(posedge clk) begin
        if (!rstN) begin
          hid[i] <= '0;
        end else if (strobe.commitDesc && pendSeg == SEG_W'(i)) begin
          hid[i] <= newDesc;
        end else if (strobe.commitNull && loadSeg == SEG_W'(i)) begin
          hid[i] <= nullDesc;
        end
      end

      // R4: a register changes only on a commit aimed at it
      p_hidden_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
        (!(strobe.commitDesc && pendSeg == SEG_W'(i)) &&
         !(strobe.commitNull && loadSeg == SEG_W'(i))) |=> $stable(hid[i]));
    end else begin : g_tie
      assign hid[i] = '0;
    end
  end

  // translation
  logic [SEG_W-1:0]  selIdx;
  hiddenDesc_t       cur;
  logic [ADDR_W-1:0] effOff;
  logic [ADDR_W-1:0] effLim;
  logic              xlOk;

  always_comb begin
    case (xlKind)
      KIND_FETCH: selIdx = SEG_CODE;
      KIND_STACK: selIdx = SEG_STACK;
      KIND_DATA:  selIdx = SEG_DATA;
      default:    selIdx = xlSeg;
    endcase
    cur    = hid[selIdx];
    effOff = cur.db ? xlOffset : ADDR_W'(xlOffset[15:0]);
    effLim = cur.gran ? {cur.limit, {PAGE_BITS{1'b1}}} : ADDR_W'(cur.limit);
    xlOk   = cur.usable && (effOff <= effLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlValid <= 1'b0;
      xlFault <= 1'b0;
      linAddr <= '0;
      xlRpl   <= '0;
      xlType  <= '0;
      xlSys   <= 1'b0;
      xlDb    <= 1'b0;
    end else begin
      xlValid <= xlReq && xlOk;
      xlFault <= xlReq && !xlOk;
      if (xlReq && xlOk) begin
        linAddr <= cur.base + effOff;
        xlRpl   <= cur.rpl;
        xlType  <= cur.segType;
        xlSys   <= cur.sysFlag;
        xlDb    <= cur.db;
      end else begin
        linAddr <= '0;
        xlRpl   <= '0;
        xlType  <= '0;
        xlSys   <= 1'b0;
        xlDb    <= 1'b0;
      end
    end
  end

  // R2: address held while the read waits
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readHi && !memAck) |=> $stable(memAddr));

  // R8: a result is either valid or faulted, never both
  p_valid_fault_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(xlValid && xlFault));

  // R7: a result appears only one cycle after a request
  p_result_after_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xlValid || xlFault) |-> $past(xlReq));

  // R8: a fault carries no address
  p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    xlFault |-> (linAddr == '0));
endmodule

// File: rtl/segXlateUnit.sv
module segXlateUnit
  import segPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadReq,
  input  logic [2:0]  loadSeg,
  input  logic [15:0] loadSel,
  output logic        loadBusy,
  output logic        loadDone,
  output logic        loadFault,
  input  logic [31:0] globalBase,
  input  logic [31:0] localBase,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memAck,
  input  logic [31:0] memData,
  input  logic        xlReq,
  input  logic [1:0]  xlKind,
  input  logic [2:0]  xlSeg,
  input  logic [31:0] xlOffset,
  output logic        xlValid,
  output logic        xlFault,
  output logic [31:0] linAddr,
  output logic [1:0]  xlRpl,
  output logic [3:0]  xlType,
  output logic        xlSys,
  output logic        xlDb
);
  ctrlStrobe_t strobe;
  logic reqNull, reqStack, reqSegBad, descOk;

  segCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadReq   (loadReq),
    .reqNull   (reqNull),
    .reqStack  (reqStack),
    .reqSegBad (reqSegBad),
    .memAck    (memAck),
    .descOk    (descOk),
    .strobe    (strobe),
    .memReq    (memReq),
    .loadBusy  (loadBusy),
    .loadDone  (loadDone),
    .loadFault (loadFault)
  );

  segDatapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .loadSel    (loadSel),
    .loadSeg    (loadSeg),
    .globalBase (globalBase),
    .localBase  (localBase),
    .memAck     (memAck),
    .memData    (memData),
    .memAddr    (memAddr),
    .reqNull    (reqNull),
    .reqStack   (reqStack),
    .reqSegBad  (reqSegBad),
    .descOk     (descOk),
    .xlReq      (xlReq),
    .xlKind     (xlKind),
    .xlSeg      (xlSeg),
    .xlOffset   (xlOffset),
    .xlValid    (xlValid),
    .xlFault    (xlFault),
    .linAddr    (linAddr),
    .xlRpl      (xlRpl),
    .xlType     (xlType),
    .xlSys      (xlSys),
    .xlDb       (xlDb)
  );

  // R10: no memory traffic outside a load
  p_mem_only_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    !loadBusy |-> !memReq);
endmodule

// File: tb/segXlateUnit_tb.sv
module segXlateUnit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadReq = 1'b0;
  logic [2:0]  loadSeg = '0;
  logic [15:0] loadSel = '0;
  logic        loadBusy, loadDone, loadFault;
  logic [31:0] globalBase = 32'h100;
  logic [31:0] localBase  = 32'h200;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [31:0] memData = '0;
  logic        xlReq = 1'b0;
  logic [1:0]  xlKind = '0;
  logic [2:0]  xlSeg = '0;
  logic [31:0] xlOffset = '0;
  logic        xlValid, xlFault;
  logic [31:0] linAddr;
  logic [1:0]  xlRpl;
  logic [3:0]  xlType;
  logic        xlSys, xlDb;

  int checks = 0;
  int failures = 0;

  segXlateUnit u_dut (.*);

  always #5 clk = ~clk;

  // memory model
  logic [31:0] mem [256];
  int waitCycles = 0;
  int waitCnt = 0;
  int readCount = 0;
  logic [31:0] readAddr [4];

  always @(negedge clk) begin
    if (memReq) begin
      if (waitCnt >= waitCycles) begin
        memAck = 1'b1;
        memData = mem[memAddr[9:2]];
        if (readCount < 4) readAddr[readCount] = memAddr;
        readCount++;
        waitCnt = 0;
      end else begin
        memAck = 1'b0;
        waitCnt++;
      end
    end else begin
      memAck = 1'b0;
      waitCnt = 0;
    end
  end

  function automatic logic [31:0] hiWord(input logic [19:0] lim, input logic [3:0] ty,
      input logic sys, input logic pres, input logic gr, input logic db, input logic [3:0] rsv);
    return {rsv, db, gr, pres, sys, ty, lim};
  endfunction

  task automatic place(input logic [31:0] tbl, input int idx, input logic [31:0] lo,
                       input logic [31:0] hi);
    logic [31:0] a;
    a = tbl + 32'(idx * 8);
    mem[a[9:2]] = lo;
    a = a + 32'd4;
    mem[a[9:2]] = hi;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doLoad(input logic [2:0] seg, input logic [15:0] sel,
                        output logic gotDone, output logic gotFault);
    int guard;
    readCount = 0;
    @(negedge clk);
    loadReq = 1'b1; loadSeg = seg; loadSel = sel;
    @(negedge clk);
    loadReq = 1'b0;
    gotDone = loadDone; gotFault = loadFault;
    guard = 0;
    while (!gotDone && !gotFault && guard < 50) begin
      @(negedge clk);
      gotDone = loadDone; gotFault = loadFault;
      guard++;
    end
  endtask

  task automatic doXlate(input logic [1:0] kind, input logic [2:0] seg, input logic [31:0] off);
    @(negedge clk);
    xlReq = 1'b1; xlKind = kind; xlSeg = seg; xlOffset = off;
    @(negedge clk);
    xlReq = 1'b0;
  endtask

  task automatic tReset();
    check("R1", "busy", 32'(loadBusy), 0);
    check("R10", "memReq idle", 32'(memReq), 0);
    doXlate(2'd0, 3'd0, 32'h10);
    check("R1", "fetch fault", 32'({xlFault, xlValid}), 32'b10);
    doXlate(2'd3, 3'd5, 32'h0);
    check("R1", "spare fault", 32'(xlFault), 1);
  endtask

  task automatic tCode();
    logic d, f;
    doLoad(3'd0, 16'h0008, d, f);
    check("R2", "code done", 32'({d, f}), 32'b10);
    check("R2", "read count", 32'(readCount), 2);
    check("R2", "low addr", readAddr[0], 32'h108);
    check("R2", "high addr", readAddr[1], 32'h10C);
    doXlate(2'd0, 3'd0, 32'h123);
    check("R7", "fetch lin", linAddr, 32'h0040_0123);
    check("R3", "attrs", 32'({xlType, xlSys, xlDb, xlRpl}), 32'({4'hA, 1'b1, 1'b1, 2'd0}));
    check("R10", "no mem on xlate", 32'(memReq), 0);
    doXlate(2'd0, 3'd0, 32'hFFF);
    check("R8", "at limit valid", 32'(xlValid), 1);
    doXlate(2'd0, 3'd0, 32'h1000);
    check("R8", "over limit", 32'({xlFault, xlValid}), 32'b10);
    check("R8", "fault addr", linAddr, 0);
  endtask

  task automatic tData();
    logic d, f;
    doLoad(3'd1, 16'h0013, d, f);
    check("R3", "data done", 32'(d), 1);
    doXlate(2'd2, 3'd0, 32'h000F_FFFF);
    check("R8", "page limit lin", linAddr, 32'h100F_FFFF);
    check("R3", "rpl", 32'(xlRpl), 3);
    doXlate(2'd2, 3'd0, 32'h0010_0000);
    check("R8", "page limit fault", 32'(xlFault), 1);
  endtask

  task automatic tLocal();
    logic d, f;
    doLoad(3'd3, 16'h0015, d, f);
    check("R2", "local low addr", readAddr[0], 32'h210);
    check("R2", "local high addr", readAddr[1], 32'h214);
    doXlate(2'd3, 3'd3, 32'h10);
    check("R6", "explicit extra", linAddr, 32'h3000_0010);
    doXlate(2'd3, 3'd3, 32'h11);
    check("R8", "byte limit fault", 32'(xlFault), 1);
  endtask

  task automatic tStack16();
    logic d, f;
    doLoad(3'd2, 16'h0018, d, f);
    check("R6", "stack done", 32'(d), 1);
    doXlate(2'd1, 3'd0, 32'hABCD_1234);
    check("R9", "16-bit offset", linAddr, 32'h2000_1234);
    check("R9", "db flag", 32'(xlDb), 0);
  endtask

  task automatic tBadDesc();
    logic d, f;
    waitCycles = 2;
    doLoad(3'd1, 16'h0020, d, f);
    check("R4", "absent fault", 32'({d, f}), 32'b01);
    doXlate(2'd2, 3'd0, 32'h4);
    check("R4", "data kept", linAddr, 32'h1000_0004);
    doLoad(3'd1, 16'h0028, d, f);
    check("R4", "reserved fault", 32'(f), 1);
    doXlate(2'd2, 3'd0, 32'h8);
    check("R4", "data kept again", linAddr, 32'h1000_0008);
    waitCycles = 0;
  endtask

  task automatic tNull();
    logic d, f;
    doLoad(3'd2, 16'h0003, d, f);
    check("R5", "null stack fault", 32'({d, f}), 32'b01);
    check("R5", "no reads", 32'(readCount), 0);
    doXlate(2'd1, 3'd0, 32'h5);
    check("R5", "stack kept", linAddr, 32'h2000_0005);
    doLoad(3'd4, 16'h0001, d, f);
    check("R5", "null spare done", 32'({d, f}), 32'b10);
    check("R5", "no reads spare", 32'(readCount), 0);
    doXlate(2'd3, 3'd4, 32'h0);
    check("R5", "null unusable", 32'(xlFault), 1);
  endtask

  task automatic tSegCode();
    logic d, f;
    doLoad(3'd6, 16'h0008, d, f);
    check("R6", "bad code load", 32'({d, f}), 32'b01);
    doXlate(2'd3, 3'd7, 32'h0);
    check("R6", "bad code xlate", 32'(xlFault), 1);
  endtask

  task automatic tWrap();
    logic d, f;
    doLoad(3'd5, 16'h0030, d, f);
    doXlate(2'd3, 3'd5, 32'h2000);
    check("R7", "wrap", linAddr, 32'h0000_1000);
  endtask

  task automatic tBusyIgnore();
    readCount = 0;
    waitCycles = 3;
    @(negedge clk);
    loadReq = 1'b1; loadSeg = 3'd0; loadSel = 16'h0010;
    @(negedge clk);
    loadSeg = 3'd1; loadSel = 16'h0008;
    @(negedge clk);
    loadReq = 1'b0;
    for (int k = 0; k < 20 && !loadDone; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R11", "two reads only", 32'(readCount), 2);
    doXlate(2'd2, 3'd0, 32'h1);
    check("R11", "data untouched", linAddr, 32'h1000_0001);
    doXlate(2'd0, 3'd0, 32'h2);
    check("R11", "code reloaded", linAddr, 32'h1000_0002);
    waitCycles = 0;
  endtask

  task automatic tOverlap();
    @(negedge clk);
    loadReq = 1'b1; loadSeg = 3'd1; loadSel = 16'h0014;
    @(negedge clk);
    loadReq = 1'b0;
    @(negedge clk);
    xlReq = 1'b1; xlKind = 2'd2; xlOffset = 32'h10;
    @(negedge clk);
    xlReq = 1'b0;
    check("R12", "commit pulse", 32'(loadDone), 1);
    check("R12", "old base", linAddr, 32'h1000_0010);
    doXlate(2'd2, 3'd0, 32'h10);
    check("R12", "new base", linAddr, 32'h3000_0010);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    place(32'h100, 1, 32'h0040_0000, hiWord(20'h00FFF, 4'hA, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0));
    place(32'h100, 2, 32'h1000_0000, hiWord(20'h000FF, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0));
    place(32'h100, 3, 32'h2000_0000, hiWord(20'h0FFFF, 4'h2, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0));
    place(32'h100, 4, 32'h5000_0000, hiWord(20'h00FFF, 4'h2, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0));
    place(32'h100, 5, 32'h6000_0000, hiWord(20'h00FFF, 4'h2, 1'b1, 1'b1, 1'b0, 1'b1, 4'h1));
    place(32'h100, 6, 32'hFFFF_F000, hiWord(20'hFFFFF, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0));
    place(32'h200, 2, 32'h3000_0000, hiWord(20'h00010, 4'h2, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCode();
    tData();
    tLocal();
    tStack16();
    tBadDesc();
    tNull();
    tSegCode();
    tWrap();
    tBusyIgnore();
    tOverlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule